// File: doc/BRIEF.md
# Delayed-Branch Fetch Squash Controller

This block steers instruction fetch for an eight-stage in-order pipeline whose branches are decided only three cycles after they are fetched. The word that follows a branch is an architectural delay slot and always completes. Fetch then carries on down the sequential path for two more cycles, as if the branch would fall through. When the branch later resolves taken, those two speculative fetches become bubbles and the program counter jumps to the target. A not-taken branch costs no cycles at all.

The decode side raises a branch flag for each fetched word. The resolution unit raises a strobe, with the outcome and the target, in the cycle the branch reaches the resolve stage. The controller supplies the fetch address, one occupancy bit for each stage, a squash pulse, and the address of the instruction leaving the last stage. Evaluating the condition and computing the target are done elsewhere.

Top module: `delay_slot_fetch_ctrl`

## Requirements
- R1: While reset is asserted, every stage_valid bit, squash and retire_valid are 0. In the first cycle after release, fetch_pc equals RESET_PC (default 0x100).
- R2: In any cycle without a squash, fetch_pc in the next cycle is the current fetch_pc plus 4.
- R3: The delay-slot instruction, which is fetched in the cycle after a branch, always retires, including when the branch is taken.
- R4: A resolve strobe with taken=1 arrives while stage 3 holds a live branch. In that same cycle squash is 1 and stage_valid bits 0 and 1 are cleared. Those two sequential fetches never retire.
- R5: In the cycle after squash is 1, fetch_pc equals the target presented with the taken resolution.
- R6: A branch resolved not-taken causes no squash. Every sequentially fetched instruction after it retires, one per cycle, with no gap.
- R7: A resolve strobe is ignored when stage 3 holds no live branch: squash stays 0 and fetch continues sequentially.
- R8: A branch flag raised for the word in a delay slot is ignored. A later taken strobe at the time that word would resolve has no effect.
- R9: A branch fetched into a squashed position is discarded. A taken strobe at its resolve time has no effect.
- R10: An instruction fetched in cycle n and not squashed is presented on retire_pc with retire_valid=1 in cycle n+7. Instructions retire in fetch order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_is_branch | input | 1 | The word fetched this cycle is a branch |
| resolve_valid | input | 1 | A branch outcome is presented this cycle |
| resolve_taken | input | 1 | Outcome: 1 taken, 0 not taken |
| resolve_target | input | AW | Target address of the resolving branch |
| fetch_pc | output | AW | Address fetched this cycle |
| stage_valid | output | STAGES | Occupancy of each stage after this cycle's squash; bit 0 is fetch |
| squash | output | 1 | The two youngest fetches are being killed |
| retire_valid | output | 1 | The last stage holds a completing instruction |
| retire_pc | output | AW | Address of the completing instruction |

## Verification
The hardest situations to reach are strobes that arrive at the exact resolve time of a branch the controller must not honour: a branch sitting in a delay slot, or a branch fetched into a position that a taken branch has just squashed. The stimulus reaches them by raising the branch flag in back-to-back or second-following fetch cycles after a real branch. It then drives a taken strobe one or two cycles after the first resolution, exactly when a wrongly tracked branch would reach stage 3. A behavioural model keeps a per-cycle fetch history and predicts every port on every cycle, and the retired address stream is scanned afterwards for the delay slot and the killed words.

// File: rtl/delay_slot_fetch_ctrl.sv
module delay_slot_fetch_ctrl #(
  parameter int AW = 32,
  parameter int STAGES = 8,
  parameter int RES_STAGE = 3,
  parameter logic [AW-1:0] RESET_PC = 'h100,
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_is_branch,
  input  logic              resolve_valid,
  input  logic              resolve_taken,
  input  logic [AW-1:0]     resolve_target,
  output logic [AW-1:0]     fetch_pc,
  output logic [STAGES-1:0] stage_valid,
  output logic              squash,
  output logic              retire_valid,
  output logic [AW-1:0]     retire_pc
);
  localparam int NKILL = RES_STAGE - 1;
  localparam logic [STAGES-1:0] KILL_MASK = STAGES'((1 << NKILL) - 1);

  logic [STAGES-1:1] vld_q;
  logic [RES_STAGE:1] br_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] spc_q [STAGES-1:1];

  wire slot_fetch = vld_q[1] & br_q[1];
  wire br_in = fetch_is_branch & ~slot_fetch;
  wire resolving = resolve_valid & vld_q[RES_STAGE] & br_q[RES_STAGE];
  wire [STAGES-1:0] occ = {vld_q, rst_n};

  assign squash = resolving & resolve_taken;
  assign stage_valid = squash ? (occ & ~KILL_MASK) : occ;
  assign fetch_pc = pc_q;
  assign retire_valid = vld_q[STAGES-1];
  assign retire_pc = spc_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      br_q  <= '0;
      pc_q  <= RESET_PC;
    end else begin
      vld_q <= stage_valid[STAGES-2:0];
      br_q  <= {br_q[RES_STAGE-1:1], br_in};
      pc_q  <= squash ? resolve_target : pc_q + AW'(STEP);
    end
  end

  always_ff @(posedge clk) begin
    spc_q[1] <= pc_q;
    for (int i = 2; i < STAGES; i++) spc_q[i] <= spc_q[i-1];
  end

  a_r5_target_next: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> fetch_pc == $past(resolve_target));
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    !squash |=> fetch_pc == $past(fetch_pc) + AW'(STEP));
  a_r4_killed_stay_dead: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> vld_q[NKILL:1] == '0);
  a_r3_slot_survives: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> vld_q[RES_STAGE]);
  a_r8_no_slot_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[RES_STAGE] & br_q[RES_STAGE]) |-> !(vld_q[RES_STAGE-1] & br_q[RES_STAGE-1]));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (stage_valid == '0 && !squash && !retire_valid));
endmodule

// File: tb/delay_slot_fetch_ctrl_test.sv
module delay_slot_fetch_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic fb = 0, rv = 0, rt = 0;
  logic [31:0] tgt = 0;
  logic [31:0] fetch_pc, retire_pc;
  logic [7:0] stage_valid;
  logic squash, retire_valid;

  delay_slot_fetch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fetch_is_branch(fb), .resolve_valid(rv),
    .resolve_taken(rt), .resolve_target(tgt), .fetch_pc(fetch_pc),
    .stage_valid(stage_valid), .squash(squash), .retire_valid(retire_valid),
    .retire_pc(retire_pc));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] h_pc[$];
  bit h_v[$], h_br[$];
  logic [31:0] got[$];
  logic [31:0] mpc = 32'h100;
  bit last_sq = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit retired(logic [31:0] a);
    foreach (got[i]) if (got[i] == a) return 1;
    return 0;
  endfunction

  task automatic cyc(bit b, bit v, bit t, logic [31:0] g, string tag);
    int n = h_pc.size();
    bit prev_br, brk, sq;
    logic [7:0] ev;
    fb = b; rv = v; rt = t; tgt = g;
    prev_br = n >= 1 && h_v[n-1] && h_br[n-1];
    brk = b && !prev_br;
    h_pc.push_back(mpc); h_v.push_back(1); h_br.push_back(brk);
    sq = n >= 3 && h_v[n-3] && h_br[n-3] && v && t;
    if (sq) begin h_v[n] = 0; h_v[n-1] = 0; end
    #1;
    chk(last_sq ? "R5" : "R2", 64'(fetch_pc), 64'(mpc));
    chk(tag, 64'(squash), 64'(sq));
    for (int k = 0; k < 8; k++) ev[k] = (n >= k) ? h_v[n-k] : 1'b0;
    chk(tag, 64'(stage_valid), 64'(ev));
    chk("R10", 64'(retire_valid), 64'(n >= 7 ? h_v[n-7] : 1'b0));
    if (n >= 7 && h_v[n-7]) chk("R10", 64'(retire_pc), 64'(h_pc[n-7]));
    if (retire_valid) got.push_back(retire_pc);
    last_sq = sq;
    mpc = sq ? g : mpc + 4;
    @(negedge clk);
  endtask

  task automatic idle(int k, string tag);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 64'(stage_valid), 0);
    chk("R1", 64'(squash), 0);
    chk("R1", 64'(retire_valid), 0);
    chk("R1", 64'(fetch_pc), 64'h100);
    rst_n = 1;
    begin
      logic [31:0] bn, bt, b8, b9, b9f;
      idle(5, "R2");
      bn = mpc;
      cyc(1, 0, 0, 0, "R6"); idle(2, "R6"); cyc(0, 1, 0, 32'h900, "R6"); idle(3, "R6");
      bt = mpc;
      cyc(1, 0, 0, 0, "R4"); idle(2, "R4"); cyc(0, 1, 1, 32'h1000, "R4"); idle(3, "R4");
      cyc(0, 1, 1, 32'h5000, "R7"); idle(4, "R7");
      b8 = mpc;
      cyc(1, 0, 0, 0, "R8"); cyc(1, 0, 0, 0, "R8"); idle(1, "R8");
      cyc(0, 1, 1, 32'h2000, "R8"); cyc(0, 1, 1, 32'h6000, "R8"); idle(4, "R8");
      b9 = mpc;
      cyc(1, 0, 0, 0, "R9"); idle(1, "R9"); cyc(1, 0, 0, 0, "R9");
      cyc(0, 1, 1, 32'h3000, "R9"); idle(1, "R9"); cyc(0, 1, 1, 32'h7000, "R9"); idle(3, "R9");
      b9f = mpc;
      cyc(1, 0, 0, 0, "R6"); idle(1, "R6"); cyc(1, 0, 0, 0, "R6");
      cyc(0, 1, 0, 32'h8000, "R6"); idle(1, "R6"); cyc(0, 1, 1, 32'h4000, "R4");
      idle(12, "R10");
      chk("R6", 64'(retired(bn + 8) && retired(bn + 12)), 1);
      chk("R3", 64'(retired(bt + 4)), 1);
      chk("R4", 64'(retired(bt + 8) || retired(bt + 12)), 0);
      chk("R8", 64'(retired(32'h6000) || retired(32'h2000 + 4)), 64'(retired(32'h2000 + 4)));
      chk("R8", 64'(retired(b8 + 4)), 1);
      chk("R9", 64'(retired(32'h7000)), 0);
      chk("R9", 64'(retired(b9 + 8)), 0);
      chk("R6", 64'(retired(b9f + 12)), 1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule